// File: doc/BRIEF.md
# Round-Robin Batch Issue Scheduler

This block decides which pixel batch feeds a 16-lane scalar ALU array on every clock. A batch carries 64 pixels, so one instruction for it occupies the array for four clocks, one lane group of 16 pixels per clock. Up to eight batches sit in active slots. A rotation pointer visits the slots in a fixed cyclic order and gives each one a four-clock visit. Batches that are not active wait in a pending pool, for example while a texture fetch is outstanding, and each presents a ready flag.

Each visit carries one instruction. On a batch's first visit after admission, a side special-function unit takes the same 16 pixels per clock as the ALU. A branch strobe marks every fourth instruction of a batch. An admitted batch stays in its slot for at least four of its own visits. After that it retires at the end of a visit if its instruction-group-done flag is set. An empty slot is refilled, just before its visit starts, with the lowest-numbered ready batch from the pool. If no batch is ready, the visit carries bubbles.

Top module: `batch_rr_sched`

## Requirements
- R1: A synchronous active-high reset empties every slot and sets the slot pointer and the lane-group index to 0, so `alu_issue_o` is 0 in the first clock after reset.
- R2: `lane_grp_o` counts 0,1,2,3 and repeats. `slot_o` holds during a visit and, after lane group 3, advances by one, wrapping from 7 to 0.
- R3: `alu_issue_o` is 1 exactly when the visited slot holds a batch, and `batch_id_o` then gives that batch's pool index.
- R4: In lane group 3 of any visit, if the next slot in rotation is empty, that slot takes the lowest-index pool batch whose ready bit is set and which no slot holds during that clock. It starts its visit in the following clock.
- R5: A batch is never held by two slots at once, even when its ready bit stays set while it is active.
- R6: An empty slot with no eligible ready batch gives a visit of four bubble clocks with `alu_issue_o` at 0.
- R7: `sfu_issue_o` is 1 during all four clocks of a batch's first visit after admission and is 0 at every other time.
- R8: `branch_o` is 1 in lane group 3 of the 4th, 8th, 12th, ... visit of a batch, and is 0 at every other time.
- R9: `retire_o` is 1 in lane group 3 of a visit when that visit is at least the batch's 4th and `grp_done_i[batch_id_o]` is 1. The slot is then empty. A set done flag has no effect during the first three visits.
- R10: `retire_o`, `branch_o` and `sfu_issue_o` are never 1 while `alu_issue_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready_i | input | 16 | Per pool batch: eligible for admission |
| grp_done_i | input | 16 | Per pool batch: instruction group finished, may retire |
| slot_o | output | 3 | Slot under visit |
| batch_id_o | output | 4 | Pool index of the batch under visit |
| lane_grp_o | output | 2 | Lane group (16 pixels) issued this clock |
| alu_issue_o | output | 1 | ALU issue strobe |
| sfu_issue_o | output | 1 | Special-function issue strobe |
| branch_o | output | 1 | Branch evaluation strobe |
| retire_o | output | 1 | Batch under visit retires at the end of this clock |

## Verification
The hardest situation to reach is a batch that stays ready while it occupies a slot, at the moment another slot comes free. Only the exclusion of active batches then stops a second admission. The stimulus drives every ready bit high with done flags low, so all eight slots fill and stay full. It then randomizes the done flags, so slots free one by one while the resident batches are still ready. A long phase with done held low walks batches through many visits and reaches the 8th and 12th visit branch strobes. A phase with a single ready batch forces bubble visits around it.

// File: rtl/bsched_pkg.sv
package bsched_pkg;
    // Default geometry of the scheduler
    localparam int unsigned DEF_SLOTS       = 8;
    localparam int unsigned DEF_BATCHES     = 16;
    localparam int unsigned DEF_LANE_GROUPS = 4;
    localparam int unsigned DEF_MIN_VISITS  = 4;
    localparam int unsigned DEF_BRANCH_GAP  = 4;

    // Width of a counter that must hold values 0..n-1 (at least one bit)
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/bsched_timer.sv
module bsched_timer
    import bsched_pkg::*;
#(
    parameter int unsigned NUM_SLOTS   = DEF_SLOTS,
    parameter int unsigned LANE_GROUPS = DEF_LANE_GROUPS,
    localparam int unsigned SW = cnt_w(NUM_SLOTS),
    localparam int unsigned LW = cnt_w(LANE_GROUPS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] slot_q,
    output logic [LW-1:0] lane_q,
    output logic          visit_end,
    output logic [SW-1:0] slot_next
);
    typedef struct packed {
        logic [SW-1:0] slot;
        logic [LW-1:0] lane;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign slot_q    = tmr_q.slot;
    assign lane_q    = tmr_q.lane;
    assign visit_end = (tmr_q.lane == LW'(LANE_GROUPS - 1));
    assign slot_next = (tmr_q.slot == SW'(NUM_SLOTS - 1)) ? '0 : tmr_q.slot + SW'(1);

    always_comb begin
        tmr_d = tmr_q;
        if (visit_end) begin
            tmr_d.lane = '0;
            tmr_d.slot = slot_next;
        end else begin
            tmr_d.lane = tmr_q.lane + LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end
endmodule

// File: rtl/bsched_pick.sv
module bsched_pick
    import bsched_pkg::*;
#(
    parameter int unsigned NUM_BATCHES = DEF_BATCHES,
    localparam int unsigned BW = cnt_w(NUM_BATCHES)
) (
    input  logic [NUM_BATCHES-1:0] cand,
    output logic                   found,
    output logic [BW-1:0]          idx
);
    // Lowest set index wins: scan downward so the last hit is the lowest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_BATCHES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = BW'(i);
            end
        end
    end
endmodule

// File: rtl/batch_rr_sched.sv
module batch_rr_sched
    import bsched_pkg::*;
#(
    parameter int unsigned NUM_SLOTS   = DEF_SLOTS,
    parameter int unsigned NUM_BATCHES = DEF_BATCHES,
    parameter int unsigned LANE_GROUPS = DEF_LANE_GROUPS,
    parameter int unsigned MIN_VISITS  = DEF_MIN_VISITS,
    parameter int unsigned BRANCH_GAP  = DEF_BRANCH_GAP,
    localparam int unsigned SW = cnt_w(NUM_SLOTS),
    localparam int unsigned BW = cnt_w(NUM_BATCHES),
    localparam int unsigned LW = cnt_w(LANE_GROUPS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_BATCHES-1:0] ready_i,
    input  logic [NUM_BATCHES-1:0] grp_done_i,
    output logic [SW-1:0]          slot_o,
    output logic [BW-1:0]          batch_id_o,
    output logic [LW-1:0]          lane_grp_o,
    output logic                   alu_issue_o,
    output logic                   sfu_issue_o,
    output logic                   branch_o,
    output logic                   retire_o
);
    localparam int unsigned AW = cnt_w(MIN_VISITS + 1);
    localparam int unsigned PW = cnt_w(BRANCH_GAP);

    typedef struct packed {
        logic [NUM_SLOTS-1:0]         vld;
        logic [NUM_SLOTS-1:0][BW-1:0] id;
        logic [NUM_SLOTS-1:0][AW-1:0] age;
        logic [NUM_SLOTS-1:0][PW-1:0] phase;
    } slots_t;

    slots_t st_d, st_q;

    logic [SW-1:0]          cur;
    logic [SW-1:0]          nxt;
    logic                   visit_end;
    logic [NUM_BATCHES-1:0] held;
    logic [NUM_BATCHES-1:0] cand;
    logic                   pick_found;
    logic [BW-1:0]          pick_idx;
    logic                   occ;
    logic [BW-1:0]          cur_id;
    logic                   matured;
    logic                   retire;

    bsched_timer #(.NUM_SLOTS(NUM_SLOTS), .LANE_GROUPS(LANE_GROUPS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .slot_q    (cur),
        .lane_q    (lane_grp_o),
        .visit_end (visit_end),
        .slot_next (nxt)
    );

    // Mask of batches currently held by a slot
    always_comb begin
        held = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (st_q.vld[s]) held[st_q.id[s]] = 1'b1;
        end
    end

    assign cand = ready_i & ~held;

    bsched_pick #(.NUM_BATCHES(NUM_BATCHES)) u_pick (
        .cand  (cand),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign occ     = st_q.vld[cur];
    assign cur_id  = st_q.id[cur];
    assign matured = (st_q.age[cur] >= AW'(MIN_VISITS - 1));
    assign retire  = occ && visit_end && matured && grp_done_i[cur_id];

    assign slot_o      = cur;
    assign batch_id_o  = cur_id;
    assign alu_issue_o = occ;
    assign sfu_issue_o = occ && (st_q.age[cur] == '0);
    assign branch_o    = occ && visit_end && (st_q.phase[cur] == PW'(BRANCH_GAP - 1));
    assign retire_o    = retire;

    always_comb begin
        st_d = st_q;
        if (occ && visit_end) begin
            if (st_q.age[cur] < AW'(MIN_VISITS))
                st_d.age[cur] = st_q.age[cur] + AW'(1);
            st_d.phase[cur] = (st_q.phase[cur] == PW'(BRANCH_GAP - 1)) ? '0
                            : st_q.phase[cur] + PW'(1);
            if (retire) st_d.vld[cur] = 1'b0;
        end
        if (visit_end && !st_d.vld[nxt] && pick_found) begin
            st_d.vld[nxt]   = 1'b1;
            st_d.id[nxt]    = pick_idx;
            st_d.age[nxt]   = '0;
            st_d.phase[nxt] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/batch_rr_sched_chk.sv
module batch_rr_sched_chk #(
    parameter int unsigned SW = 3,
    parameter int unsigned LW = 2,
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned LANE_GROUPS = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [SW-1:0] slot_o,
    input logic [LW-1:0] lane_grp_o,
    input logic          alu_issue_o,
    input logic          sfu_issue_o,
    input logic          branch_o,
    input logic          retire_o
);
    // R1: state after a reset clock
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (slot_o == '0 && lane_grp_o == '0 && !alu_issue_o));

    // R2: lane group steps inside a visit, slot held
    a_r2_lane_step: assert property (@(posedge clk) disable iff (rst)
        (lane_grp_o != LW'(LANE_GROUPS - 1)) |=>
        (lane_grp_o == $past(lane_grp_o) + LW'(1) && slot_o == $past(slot_o)));

    // R2: slot advances with wrap after the last lane group
    a_r2_slot_wrap: assert property (@(posedge clk) disable iff (rst)
        (lane_grp_o == LW'(LANE_GROUPS - 1)) |=>
        (lane_grp_o == '0 &&
         slot_o == (($past(slot_o) == SW'(NUM_SLOTS - 1)) ? '0 : $past(slot_o) + SW'(1))));

    // R9: retire only in the last lane group
    a_r9_retire_lane: assert property (@(posedge clk) disable iff (rst)
        retire_o |-> (lane_grp_o == LW'(LANE_GROUPS - 1)));

    // R8: branch only in the last lane group
    a_r8_branch_lane: assert property (@(posedge clk) disable iff (rst)
        branch_o |-> (lane_grp_o == LW'(LANE_GROUPS - 1)));

    // R7: special-function issue stays on for a whole visit once begun
    a_r7_sfu_hold: assert property (@(posedge clk) disable iff (rst)
        (sfu_issue_o && lane_grp_o != LW'(LANE_GROUPS - 1)) |=> sfu_issue_o);

    // R10: side strobes need an ALU issue
    a_r10_side_gated: assert property (@(posedge clk) disable iff (rst)
        (sfu_issue_o || branch_o || retire_o) |-> alu_issue_o);
endmodule

bind batch_rr_sched batch_rr_sched_chk #(
    .SW(SW), .LW(LW), .NUM_SLOTS(NUM_SLOTS), .LANE_GROUPS(LANE_GROUPS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .slot_o      (slot_o),
    .lane_grp_o  (lane_grp_o),
    .alu_issue_o (alu_issue_o),
    .sfu_issue_o (sfu_issue_o),
    .branch_o    (branch_o),
    .retire_o    (retire_o)
);

// File: tb/batch_rr_sched_test.sv
module batch_rr_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NB = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] ready_i = '0;
    logic [NB-1:0] grp_done_i = '0;
    logic [2:0]    slot_o;
    logic [3:0]    batch_id_o;
    logic [1:0]    lane_grp_o;
    logic          alu_issue_o, sfu_issue_o, branch_o, retire_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Behavioural reference state
    bit m_vld [NS];
    int m_id  [NS];
    int m_vis [NS];
    int m_slot, m_lane;

    batch_rr_sched uut (
        .clk(clk), .rst(rst), .ready_i(ready_i), .grp_done_i(grp_done_i),
        .slot_o(slot_o), .batch_id_o(batch_id_o), .lane_grp_o(lane_grp_o),
        .alu_issue_o(alu_issue_o), .sfu_issue_o(sfu_issue_o),
        .branch_o(branch_o), .retire_o(retire_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_vld[s] = 0; m_id[s] = 0; m_vis[s] = 0;
        end
        m_slot = 0; m_lane = 0;
    endtask

    // Compare outputs with the model, then advance the model one clock
    task automatic compare_and_step();
        bit e_alu, e_sfu, e_br, e_ret;
        int nxt, pick;
        bit held [NB];
        e_alu = m_vld[m_slot];
        e_sfu = e_alu && m_vis[m_slot] == 0;
        e_br  = e_alu && m_lane == 3 && (m_vis[m_slot] % 4) == 3;
        e_ret = e_alu && m_lane == 3 && m_vis[m_slot] >= 3 && grp_done_i[m_id[m_slot]];
        chk("R2 lane", int'(lane_grp_o), m_lane);
        chk("R2 slot", int'(slot_o), m_slot);
        chk(m_vld[m_slot] ? "R3 alu" : "R6 bubble", int'(alu_issue_o), int'(e_alu));
        if (e_alu) chk("R3 R4 R5 batch id", int'(batch_id_o), m_id[m_slot]);
        chk("R7 sfu", int'(sfu_issue_o), int'(e_sfu));
        chk("R8 branch", int'(branch_o), int'(e_br));
        chk("R9 retire", int'(retire_o), int'(e_ret));
        chk("R10 gating", int'((sfu_issue_o || branch_o || retire_o) && !alu_issue_o), 0);
        if (m_lane == 3) begin
            for (int b = 0; b < NB; b++) held[b] = 0;
            for (int s = 0; s < NS; s++) if (m_vld[s]) held[m_id[s]] = 1;
            if (e_alu) m_vis[m_slot]++;
            if (e_ret) m_vld[m_slot] = 0;
            nxt = (m_slot + 1) % NS;
            if (!m_vld[nxt]) begin
                pick = -1;
                for (int b = NB - 1; b >= 0; b--) if (ready_i[b] && !held[b]) pick = b;
                if (pick >= 0) begin
                    m_vld[nxt] = 1; m_id[nxt] = pick; m_vis[nxt] = 0;
                end
            end
            m_slot = nxt;
            m_lane = 0;
        end else begin
            m_lane++;
        end
    endtask

    // mode 0: all ready, all done; 1: none ready; 2: random;
    // 3: all ready, done low; 4: single ready batch 9; 5: batches 5 and 12
    task automatic run(input int mode, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            case (mode)
                0: begin ready_i = '1; grp_done_i = '1; end
                1: begin ready_i = '0; grp_done_i = '1; end
                2: begin ready_i = NB'($urandom); grp_done_i = NB'($urandom); end
                3: begin ready_i = '1; grp_done_i = '0; end
                4: begin ready_i = NB'(1 << 9); grp_done_i = '1; end
                default: begin ready_i = NB'((1 << 5) | (1 << 12)); grp_done_i = NB'($urandom); end
            endcase
            #1;
            compare_and_step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 slot after reset", int'(slot_o), 0);
        chk("R1 lane after reset", int'(lane_grp_o), 0);
        chk("R1 alu after reset", int'(alu_issue_o), 0);
        compare_and_step();
        run(0, 600);
        run(1, 400);
        run(3, 1200);
        run(2, 1500);
        run(1, 300);
        run(4, 500);
        run(5, 800);
        run(2, 800);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule